// File: doc/BRIEF.md
# Row-Buffer-Locality Migration Tracker

In a hybrid memory controller with a small fast tier and a large slow tier, this block watches the stream of slow-tier accesses. For every access it receives the row address and a flag that says whether the access missed the open row buffer. It counts those row-buffer misses per row in a small set-associative table that only holds recently used rows. A row that keeps missing the row buffer gains little from staying in the slow tier, so once its miss count reaches a threshold the block asks for it to be moved to the fast tier.

The threshold is a plain input that an outside policy may change at any cycle. A separate interval signal wipes the whole table in one cycle, so that only rows that are reused within one interval can ever be promoted. A combinational lookup port reports the current miss count of any row, or zero when the row is not tracked.

Top module: `rbl_tracker`

## Requirements
- R1: After reset no row is tracked: the lookup port returns 0 for every row and `mig_valid` is low.
- R2: An access with `acc_slow` low (a fast-tier access) changes no count, allocates nothing and raises no migrate request.
- R3: A slow-tier access with `acc_rb_miss` low leaves the count of a tracked row unchanged and allocates no entry for an untracked row.
- R4: A slow-tier access with `acc_rb_miss` high to an untracked row allocates an entry with count 1; when `thresh` is 0 or 1 it instead raises a migrate request and allocates nothing.
- R5: A slow-tier row-buffer-miss access to a tracked row adds 1 to its count, which saturates at 2^CNT_W-1.
- R6: When the count after a slow-tier row-buffer-miss access is greater than or equal to `thresh`, `mig_valid` is high for exactly the next cycle with `mig_row` equal to that access's row, and the row's entry is invalidated so the lookup returns 0.
- R7: The set index is the low log2(SETS) bits of the row address and the remaining high bits are the tag; rows in different sets never displace each other.
- R8: Allocation takes the lowest-numbered invalid way of the set; if all ways are valid it evicts the least recently used one, where any slow-tier access to a tracked row (either flag) and any allocation make that way the most recent.
- R9: `interval_clr` invalidates every entry in one cycle; an access presented in the same cycle is discarded and raises no migrate request.
- R10: `thresh` is sampled in the cycle of each access, so a changed value applies from the next access on.
- R11: `lk_count` is a combinational function of `lk_row` and the table state: the row's count if tracked, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_slow | input | 1 | 1: access targets the slow tier; 0: fast tier |
| acc_row | input | ROW_W | Row address of the access |
| acc_rb_miss | input | 1 | 1: the access missed the row buffer |
| thresh | input | CNT_W+1 | Miss count at which a row is promoted |
| interval_clr | input | 1 | End of interval: clear the whole table |
| mig_valid | output | 1 | One-cycle migrate request |
| mig_row | output | ROW_W | Row to move to the fast tier |
| lk_row | input | ROW_W | Row address to look up |
| lk_count | output | CNT_W | Miss count of `lk_row`, 0 if untracked |

## Verification
A wrong count, tag or valid bit shows at the lookup port in the very cycle after the access that wrote it, because the lookup reads the table with no register in between, and it shows at `mig_valid` one cycle after the access that should (or should not) have crossed the threshold. A wrong recency order stays hidden until a set is full and a fresh row is allocated; the evicted row then reads 0 while the row that should have gone still reads its count, so conflict-heavy traffic on few sets and ways is what exposes it.

// File: rtl/rbl_pkg.sv
package rbl_pkg;
  localparam int unsigned RBL_SETS  = 128;
  localparam int unsigned RBL_WAYS  = 16;
  localparam int unsigned RBL_CNT_W = 4;
  localparam int unsigned RBL_ROW_W = 24;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_TOUCH,
    OP_COUNT,
    OP_PROMOTE_HIT,
    OP_ALLOC,
    OP_PROMOTE_NEW
  } rbl_op_e;
endpackage

// File: rtl/rbl_way_match.sv
module rbl_way_match #(
  parameter int unsigned WAYS  = 16,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/rbl_victim.sv
module rbl_victim #(
  parameter int unsigned WAYS = 16,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][WAY_W-1:0]  ages,
  output logic [WAY_W-1:0]            victim
);
  logic free_found;

  always_comb begin
    victim     = '0;
    free_found = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        victim     = WAY_W'(w);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ages[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/rbl_age_update.sv
module rbl_age_update #(
  parameter int unsigned WAYS = 16,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0]  ages_in,
  input  logic [WAY_W-1:0]            touch_way,
  output logic [WAYS-1:0][WAY_W-1:0]  ages_out
);
  logic [WAY_W-1:0] touched_age;
  assign touched_age = ages_in[touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    always_comb begin
      if (WAY_W'(w) == touch_way)        ages_out[w] = '0;
      else if (ages_in[w] < touched_age) ages_out[w] = ages_in[w] + 1'b1;
      else                               ages_out[w] = ages_in[w];
    end
  end
endmodule

// File: rtl/rbl_tracker.sv
module rbl_tracker #(
  parameter int unsigned SETS  = rbl_pkg::RBL_SETS,
  parameter int unsigned WAYS  = rbl_pkg::RBL_WAYS,
  parameter int unsigned CNT_W = rbl_pkg::RBL_CNT_W,
  parameter int unsigned ROW_W = rbl_pkg::RBL_ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_slow,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic              acc_rb_miss,
  input  logic [CNT_W:0]    thresh,
  input  logic              interval_clr,
  output logic              mig_valid,
  output logic [ROW_W-1:0]  mig_row,
  input  logic [ROW_W-1:0]  lk_row,
  output logic [CNT_W-1:0]  lk_count
);
  import rbl_pkg::*;

  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = ROW_W - SET_W;
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Table state: one row of packed ways per set
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][CNT_W-1:0]  cnt_q   [SETS];
  logic [WAYS-1:0][WAY_W-1:0]  age_q   [SETS];
  logic                        mig_valid_q;
  logic [ROW_W-1:0]            mig_row_q;

  // Access-side decode
  logic [SET_W-1:0] acc_set;
  logic [TAG_W-1:0] acc_tag;
  logic             take;
  assign acc_set = acc_row[SET_W-1:0];
  assign acc_tag = acc_row[ROW_W-1:SET_W];
  assign take    = acc_valid && acc_slow && !interval_clr;

  logic [WAYS-1:0]  a_hit_vec;
  logic             a_hit;
  logic [WAY_W-1:0] a_way;
  logic [WAY_W-1:0] v_way;

  rbl_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_acc_match (
    .valid   (valid_q[acc_set]),
    .tags    (tag_q[acc_set]),
    .key     (acc_tag),
    .hit_vec (a_hit_vec),
    .hit     (a_hit),
    .hit_way (a_way)
  );

  rbl_victim #(.WAYS(WAYS)) u_victim (
    .valid  (valid_q[acc_set]),
    .ages   (age_q[acc_set]),
    .victim (v_way)
  );

  // Next-state for the addressed set
  rbl_op_e                     op;
  logic [CNT_W-1:0]            cur_cnt;
  logic [CNT_W-1:0]            inc_cnt;
  logic [WAY_W-1:0]            touch_way;
  logic [WAYS-1:0][WAY_W-1:0]  ages_touched;
  logic [WAYS-1:0]             row_valid_d;
  logic [WAYS-1:0][TAG_W-1:0]  row_tag_d;
  logic [WAYS-1:0][CNT_W-1:0]  row_cnt_d;
  logic                        row_we;
  logic                        age_we;
  logic                        mig_d;

  assign cur_cnt = cnt_q[acc_set][a_way];
  assign inc_cnt = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;

  always_comb begin
    op = OP_IDLE;
    if (take) begin
      if (a_hit) begin
        if (!acc_rb_miss)                op = OP_TOUCH;
        else if ({1'b0, inc_cnt} >= thresh) op = OP_PROMOTE_HIT;
        else                             op = OP_COUNT;
      end else if (acc_rb_miss) begin
        if (thresh <= (CNT_W+1)'(1))     op = OP_PROMOTE_NEW;
        else                             op = OP_ALLOC;
      end
    end
  end

  assign touch_way = (op == OP_ALLOC) ? v_way : a_way;

  rbl_age_update #(.WAYS(WAYS)) u_age (
    .ages_in   (age_q[acc_set]),
    .touch_way (touch_way),
    .ages_out  (ages_touched)
  );

  always_comb begin
    row_valid_d = valid_q[acc_set];
    row_tag_d   = tag_q[acc_set];
    row_cnt_d   = cnt_q[acc_set];
    row_we      = 1'b0;
    age_we      = 1'b0;
    mig_d       = 1'b0;
    unique case (op)
      OP_TOUCH: age_we = 1'b1;
      OP_COUNT: begin
        row_cnt_d[a_way] = inc_cnt;
        row_we = 1'b1;
        age_we = 1'b1;
      end
      OP_PROMOTE_HIT: begin
        row_valid_d[a_way] = 1'b0;
        row_we = 1'b1;
        age_we = 1'b1;
        mig_d  = 1'b1;
      end
      OP_ALLOC: begin
        row_valid_d[v_way] = 1'b1;
        row_tag_d[v_way]   = acc_tag;
        row_cnt_d[v_way]   = CNT_W'(1);
        row_we = 1'b1;
        age_we = 1'b1;
      end
      OP_PROMOTE_NEW: mig_d = 1'b1;
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tag_q[s]   <= '0;
        cnt_q[s]   <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
      mig_valid_q <= 1'b0;
      mig_row_q   <= '0;
    end else begin
      if (interval_clr) begin
        for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (row_we) begin
        valid_q[acc_set] <= row_valid_d;
        tag_q[acc_set]   <= row_tag_d;
        cnt_q[acc_set]   <= row_cnt_d;
      end
      if (age_we) age_q[acc_set] <= ages_touched;
      mig_valid_q <= mig_d;
      if (mig_d) mig_row_q <= acc_row;
    end
  end

  assign mig_valid = mig_valid_q;
  assign mig_row   = mig_row_q;

  // Lookup side
  logic [WAYS-1:0]  l_hit_vec;
  logic             l_hit;
  logic [WAY_W-1:0] l_way;
  logic [SET_W-1:0] lk_set;
  assign lk_set = lk_row[SET_W-1:0];

  rbl_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid   (valid_q[lk_set]),
    .tags    (tag_q[lk_set]),
    .key     (lk_row[ROW_W-1:SET_W]),
    .hit_vec (l_hit_vec),
    .hit     (l_hit),
    .hit_way (l_way)
  );

  assign lk_count = l_hit ? cnt_q[lk_set][l_way] : '0;

  // Assertions
  assert_fast_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_slow) |=> !mig_valid);

  assert_mig_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> $past(acc_valid && acc_slow && acc_rb_miss && !interval_clr));

  assert_mig_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> (mig_row == $past(acc_row)));

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(a_hit_vec) && $onehot0(l_hit_vec));

  assert_clear_wipes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    interval_clr |=> (lk_count == '0) && !mig_valid);

  assert_hit_flag_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !acc_rb_miss) |=> !mig_valid);
endmodule

// File: tb/rbl_tracker_bench.sv
`timescale 1ns/1ps
module rbl_tracker_bench;
  localparam int SETS = 4, WAYS = 2, CNT_W = 3, ROW_W = 6;
  localparam int CMAX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_slow = 0, acc_rb_miss = 0, interval_clr = 0;
  logic [ROW_W-1:0] acc_row = '0, lk_row = '0;
  logic [CNT_W:0] thresh = '0;
  logic mig_valid;
  logic [ROW_W-1:0] mig_row;
  logic [CNT_W-1:0] lk_count;

  int checks = 0, errors = 0;
  int thr = 3;
  int tick = 0;
  bit m_valid [SETS][WAYS];
  int m_tag   [SETS][WAYS];
  int m_cnt   [SETS][WAYS];
  int m_stamp [SETS][WAYS];

  always #2.5 clk = ~clk;

  rbl_tracker #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W), .ROW_W(ROW_W)) u_rbl_tracker (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_slow(acc_slow),
    .acc_row(acc_row), .acc_rb_miss(acc_rb_miss), .thresh(thresh),
    .interval_clr(interval_clr), .mig_valid(mig_valid), .mig_row(mig_row),
    .lk_row(lk_row), .lk_count(lk_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_count(input int row);
    int s = row % SETS, tg = row / SETS;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == tg) return m_cnt[s][w];
    return 0;
  endfunction

  task automatic model_step(input bit v, input bit slow, input bit miss, input bit clr,
                            input int row, output bit em);
    int s = row % SETS, tg = row / SETS, hw = -1, vw = -1, inc;
    em = 0;
    if (clr) begin
      for (int a = 0; a < SETS; a++) for (int w = 0; w < WAYS; w++) m_valid[a][w] = 0;
      return;
    end
    if (!v || !slow) return;
    tick++;
    for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == tg) hw = w;
    if (hw >= 0) begin
      m_stamp[s][hw] = tick;
      if (miss) begin
        inc = (m_cnt[s][hw] == CMAX) ? CMAX : m_cnt[s][hw] + 1;
        if (inc >= thr) begin m_valid[s][hw] = 0; em = 1; end
        else m_cnt[s][hw] = inc;
      end
    end else if (miss) begin
      if (thr <= 1) em = 1;
      else begin
        for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[s][w]) vw = w;
        if (vw < 0) begin
          vw = 0;
          for (int w = 1; w < WAYS; w++) if (m_stamp[s][w] < m_stamp[s][vw]) vw = w;
        end
        m_valid[s][vw] = 1; m_tag[s][vw] = tg; m_cnt[s][vw] = 1; m_stamp[s][vw] = tick;
      end
    end
  endtask

  // Drive one cycle at a negedge, check migrate output at the following negedge.
  task automatic access(input bit slow, input int row, input bit miss, input bit clr, input string req);
    bit em;
    acc_valid = 1; acc_slow = slow; acc_row = ROW_W'(row); acc_rb_miss = miss;
    interval_clr = clr; thresh = (CNT_W+1)'(thr);
    model_step(1, slow, miss, clr, row, em);
    @(posedge clk); @(negedge clk);
    acc_valid = 0; acc_slow = 0; acc_rb_miss = 0; interval_clr = 0;
    chk(mig_valid == em, req, mig_valid, em);
    if (em) chk(mig_row == ROW_W'(row), req, mig_row, row);
  endtask

  task automatic look(input int row, input string req);
    lk_row = ROW_W'(row);
    #0.5;
    chk(lk_count == CNT_W'(model_count(row)), req, lk_count, model_count(row));
  endtask

  task automatic idle_cycle(input string req);
    @(posedge clk); @(negedge clk);
    chk(mig_valid == 0, req, mig_valid, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 0; m_tag[s][w] = 0; m_cnt[s][w] = 0; m_stamp[s][w] = -w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mig_valid == 0, "R1", mig_valid, 0);
    for (int row = 0; row < 64; row += 9) look(row, "R1");

    // R4 allocate, R3 hit flag, R2 fast tier
    thr = 3;
    access(1, 5, 1, 0, "R4"); look(5, "R4");
    access(1, 5, 0, 0, "R3"); look(5, "R3");
    access(1, 9, 0, 0, "R3"); look(9, "R3");
    access(0, 5, 1, 0, "R2"); look(5, "R2");
    access(0, 13, 1, 0, "R2"); look(13, "R2");
    // R5 count, R6 promotion and invalidation
    access(1, 5, 1, 0, "R5"); look(5, "R5");
    access(1, 5, 1, 0, "R6"); look(5, "R6");
    idle_cycle("R6");

    // R5 saturation with a threshold above the counter maximum
    thr = 8;
    for (int i = 0; i < 10; i++) access(1, 6, 1, 0, "R5");
    look(6, "R5");

    // R8 / R7 set conflicts in set 1, neighbour in set 2
    access(1, 2, 1, 0, "R7");
    access(1, 1, 1, 0, "R8");
    access(1, 17, 1, 0, "R8");
    access(1, 1, 0, 0, "R8");
    access(1, 33, 1, 0, "R8");
    look(1, "R8"); look(17, "R8"); look(33, "R8"); look(2, "R7"); look(6, "R7");

    // R9 clear with same-cycle access
    thr = 2;
    access(1, 33, 1, 1, "R9");
    look(33, "R9"); look(1, "R9"); look(6, "R9"); look(2, "R9");

    // R10 runtime threshold change, R4 immediate promotion
    thr = 8;
    access(1, 10, 1, 0, "R10"); access(1, 10, 1, 0, "R10");
    thr = 3;
    access(1, 10, 1, 0, "R10"); look(10, "R10");
    thr = 1;
    access(1, 11, 1, 0, "R4"); look(11, "R4");
    thr = 0;
    access(1, 12, 1, 0, "R4"); look(12, "R4");

    // Random traffic against the model
    thr = 4;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 50) == 0) thr = 1 + ($urandom % 8);
      r = $urandom % 24;
      access(($urandom % 8) != 0, r, ($urandom % 3) != 0, ($urandom % 80) == 0, "R11");
      look($urandom % 24, "R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule